// File: doc/BRIEF.md
# Pulse-Swallow Frequency Divider

This block sets the loop ratio of a synthesizer. A dual-modulus prescaler model counts VCO edges and divides by P or P+1. It is driven by a swallow counter and a main counter, so that one full output period spans exactly P·N + A VCO edges. Beside it, a reference divider produces one output pulse for every R reference edges. Both divided pulse streams feed a phase comparator and a lock detector that sit outside this block.

In this model, each VCO edge and each reference edge is a one-cycle `vco_tick` or `ref_tick` enable in the system clock domain. A ratio set holds a modulus choice, N, A and R. It is offered with a one-cycle `cfg_load` strobe and checked for legality. A legal set is held as pending and copied into use only at each divider's next period boundary. With `FIXED=1` the instance ignores its configuration inputs and runs a 16/17 prescaler with N = 291, A = 7 and R = 384. With a 19.2 MHz reference this gives a 50 kHz comparison rate.

The swallow controller is a two-state machine:
- SWALLOW: the prescaler is held at P+1. The machine stays here until A prescaler cycles have completed, then moves to MAIN (transition *swallow-done*).
- MAIN: the prescaler runs at P. At the end of the N-th prescaler cycle the machine emits the output pulse, reloads the pending set and picks its next state (transition *period-wrap*). The next state is SWALLOW if the new A is non-zero and MAIN if A is zero (transition *wrap-skip*).

Top module: `pswal_top`

## Requirements
- R1: With `cfg_small`=0 (128/129 modulus), `div_pulse` fires once every 128·N + A `vco_tick` edges.
- R2: With `cfg_small`=1 (64/65 modulus), `div_pulse` fires once every 64·N + A `vco_tick` edges.
- R3: Each output period runs A prescaler cycles at P+1 followed by N − A cycles at P. This holds at the boundary cases A = 0 and A = N − 1.
- R4: `ref_pulse` fires once every R `ref_tick` edges.
- R5: A legal set loaded mid-period leaves the current period of each divider unchanged. It applies from the following period on.
- R6: A load is rejected when N < 5, R < 5, A ≥ N, or A > 63 with `cfg_small`=1. A rejected load sets `cfg_err` to 1 and leaves the ratios in use unchanged. A legal load clears `cfg_err` to 0.
- R7: Reset holds `div_pulse`, `ref_pulse` and `cfg_err` at 0. After reset the programmable instance runs its default set: 128/129 modulus, N = 6, A = 3, R = 7.
- R8: With `FIXED`=1 the periods are 4663 VCO edges and 384 reference edges, whatever is loaded, and `cfg_err` stays 0.
- R9: Each output pulse is one clock wide. It appears in the cycle after the edge that completes its period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_tick | input | 1 | One VCO edge in this cycle |
| ref_tick | input | 1 | One reference edge in this cycle |
| cfg_load | input | 1 | Offer a new ratio set this cycle |
| cfg_small | input | 1 | 1 = 64/65 modulus, 0 = 128/129 modulus |
| cfg_n | input | 11 | Main counter ratio N |
| cfg_a | input | 7 | Swallow count A |
| cfg_r | input | 14 | Reference ratio R |
| div_pulse | output | 1 | Divided VCO pulse |
| ref_pulse | output | 1 | Divided reference pulse |
| cfg_err | output | 1 | Last offered set was illegal |

## Verification
Two events can share one clock edge: a configuration load and a divider's period wrap. The rule is that the wrap copies the pending set as it stood before that edge. The bench writes each new set right after a VCO pulse, so the load meets a VCO period at its very start. It then counts VCO edges per period and compares them against a queue of expected lengths, with the old length still expected for the period already running. On the reference side, the reference stream is masked in the load cycle, so any reference wrap falls on a later edge. The expected length is updated only after the load has been taken, and every reference period is judged against R.

// File: rtl/pswal_pkg.sv
package pswal_pkg;
    localparam int N_W = 11;   // main counter ratio width
    localparam int A_W = 7;    // swallow count width
    localparam int R_W = 14;   // reference ratio width
    localparam int P_W = 8;    // prescaler modulus width
    localparam int MIN_RATIO = 5;

    typedef enum logic {
        PH_SWALLOW = 1'b0,
        PH_MAIN    = 1'b1
    } phase_t;
endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
    import pswal_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [P_W-1:0] base,
    input  logic           hi,
    output logic           pre_done
);
    logic [P_W:0] pc_q;
    logic [P_W:0] last;

    assign last     = {1'b0, base} + {{P_W{1'b0}}, hi} - {{P_W{1'b0}}, 1'b1};
    assign pre_done = tick && (pc_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pc_q <= '0;
        else if (tick)
            pc_q <= pre_done ? '0 : pc_q + 1'b1;
    end

    assert_pc_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q <= last);
endmodule

// File: rtl/pswal_swallow_fsm.sv
module pswal_swallow_fsm
    import pswal_pkg::*;
#(
    parameter int DEF_N     = 6,
    parameter int DEF_A     = 3,
    parameter bit DEF_SMALL = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_done,
    input  logic [N_W-1:0] pend_n,
    input  logic [A_W-1:0] pend_a,
    input  logic           pend_small,
    output logic           mod_hi,
    output logic           act_small,
    output logic           div_pulse
);
    localparam phase_t RST_PH = (DEF_A != 0) ? PH_SWALLOW : PH_MAIN;

    phase_t         state_q, state_d;
    logic [N_W-1:0] cnt_q;
    logic [N_W-1:0] act_n;
    logic [A_W-1:0] act_a;
    logic [N_W-1:0] act_a_ext;
    logic           swallow_done;
    logic           period_end;
    logic           pulse_q;

    assign act_a_ext    = {{(N_W-A_W){1'b0}}, act_a};
    assign swallow_done = (state_q == PH_SWALLOW) && pre_done && (cnt_q == act_a_ext - 1'b1);
    assign period_end   = (state_q == PH_MAIN) && pre_done && (cnt_q == act_n - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RST_PH;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_SWALLOW: if (swallow_done) state_d = PH_MAIN;
            PH_MAIN:    if (period_end)   state_d = (pend_a != '0) ? PH_SWALLOW : PH_MAIN;
            default:    state_d = RST_PH;
        endcase
    end

    // outputs
    always_comb begin
        mod_hi    = (state_q == PH_SWALLOW);
        div_pulse = pulse_q;
    end

    // counters and active ratio set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            act_n     <= N_W'(DEF_N);
            act_a     <= A_W'(DEF_A);
            act_small <= DEF_SMALL;
            pulse_q   <= 1'b0;
        end else begin
            pulse_q <= period_end;
            if (period_end) begin
                cnt_q     <= '0;
                act_n     <= pend_n;
                act_a     <= pend_a;
                act_small <= pend_small;
            end else if (pre_done) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_mod_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_done |=> $stable(mod_hi));
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_n);
    assert_active_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_a_ext < act_n) && (act_n >= N_W'(MIN_RATIO)));
    assert_pulse_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
endmodule

// File: rtl/pswal_refdiv.sv
module pswal_refdiv
    import pswal_pkg::*;
#(
    parameter int DEF_R = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_tick,
    input  logic [R_W-1:0] pend_r,
    output logic           ref_pulse
);
    logic [R_W-1:0] rcnt_q;
    logic [R_W-1:0] act_r;
    logic           wrap;

    assign wrap = ref_tick && (rcnt_q == act_r - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt_q    <= '0;
            act_r     <= R_W'(DEF_R);
            ref_pulse <= 1'b0;
        end else begin
            ref_pulse <= wrap;
            if (wrap) begin
                rcnt_q <= '0;
                act_r  <= pend_r;
            end else if (ref_tick) begin
                rcnt_q <= rcnt_q + 1'b1;
            end
        end
    end

    assert_ref_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_r >= R_W'(MIN_RATIO));
    assert_ref_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> $past(ref_tick));
endmodule

// File: rtl/pswal_top.sv
module pswal_top
    import pswal_pkg::*;
#(
    parameter bit FIXED     = 1'b0,
    parameter int P_SMALL   = 64,
    parameter int P_LARGE   = 128,
    parameter int FIX_P     = 16,
    parameter int FIX_N     = 291,
    parameter int FIX_A     = 7,
    parameter int FIX_R     = 384,
    parameter int DEF_N     = 6,
    parameter int DEF_A     = 3,
    parameter int DEF_R     = 7,
    parameter bit DEF_SMALL = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vco_tick,
    input  logic           ref_tick,
    input  logic           cfg_load,
    input  logic           cfg_small,
    input  logic [N_W-1:0] cfg_n,
    input  logic [A_W-1:0] cfg_a,
    input  logic [R_W-1:0] cfg_r,
    output logic           div_pulse,
    output logic           ref_pulse,
    output logic           cfg_err
);
    localparam int RST_N = FIXED ? FIX_N : DEF_N;
    localparam int RST_A = FIXED ? FIX_A : DEF_A;
    localparam int RST_R = FIXED ? FIX_R : DEF_R;

    logic [N_W-1:0] pend_n;
    logic [A_W-1:0] pend_a;
    logic [R_W-1:0] pend_r;
    logic           pend_small;
    logic           mod_hi;
    logic           act_small;
    logic           pre_done;
    logic [P_W-1:0] base;

    generate
        if (FIXED) begin : g_fixed
            assign pend_n     = N_W'(FIX_N);
            assign pend_a     = A_W'(FIX_A);
            assign pend_r     = R_W'(FIX_R);
            assign pend_small = 1'b0;
            assign cfg_err    = 1'b0;
            assign base       = P_W'(FIX_P);
        end else begin : g_prog
            logic cfg_ok;
            logic err_q;

            assign cfg_ok = (cfg_n >= N_W'(MIN_RATIO)) && (cfg_r >= R_W'(MIN_RATIO))
                         && ({{(N_W-A_W){1'b0}}, cfg_a} < cfg_n)
                         && (!cfg_small || ({1'b0, cfg_a} < (A_W+1)'(P_SMALL)));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_n     <= N_W'(DEF_N);
                    pend_a     <= A_W'(DEF_A);
                    pend_r     <= R_W'(DEF_R);
                    pend_small <= DEF_SMALL;
                    err_q      <= 1'b0;
                end else if (cfg_load) begin
                    err_q <= !cfg_ok;
                    if (cfg_ok) begin
                        pend_n     <= cfg_n;
                        pend_a     <= cfg_a;
                        pend_r     <= cfg_r;
                        pend_small <= cfg_small;
                    end
                end
            end

            assign cfg_err = err_q;
            assign base    = act_small ? P_W'(P_SMALL) : P_W'(P_LARGE);

            assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_load && !cfg_ok) |=> ($stable(pend_n) && $stable(pend_a)
                                           && $stable(pend_r) && $stable(pend_small)));
        end
    endgenerate

    pswal_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (vco_tick),
        .base     (base),
        .hi       (mod_hi),
        .pre_done (pre_done)
    );

    pswal_swallow_fsm #(
        .DEF_N     (RST_N),
        .DEF_A     (RST_A),
        .DEF_SMALL (FIXED ? 1'b0 : DEF_SMALL)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_done   (pre_done),
        .pend_n     (pend_n),
        .pend_a     (pend_a),
        .pend_small (pend_small),
        .mod_hi     (mod_hi),
        .act_small  (act_small),
        .div_pulse  (div_pulse)
    );

    pswal_refdiv #(
        .DEF_R (RST_R)
    ) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .pend_r    (pend_r),
        .ref_pulse (ref_pulse)
    );
endmodule

// File: tb/pswal_top_tb.sv
module pswal_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vco_tick = 1'b0;
    logic        ref_raw = 1'b0;
    logic        ref_tick;
    logic        cfg_load = 1'b0;
    logic        cfg_small = 1'b0;
    logic [10:0] cfg_n = '0;
    logic [6:0]  cfg_a = '0;
    logic [13:0] cfg_r = '0;
    logic        div_pulse, ref_pulse, cfg_err;
    logic        fx_div, fx_ref, fx_err;

    assign ref_tick = ref_raw & ~cfg_load;

    always #10 clk = ~clk;   // 50 MHz

    pswal_top u_dut (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .cfg_load(cfg_load), .cfg_small(cfg_small), .cfg_n(cfg_n), .cfg_a(cfg_a),
        .cfg_r(cfg_r), .div_pulse(div_pulse), .ref_pulse(ref_pulse), .cfg_err(cfg_err)
    );

    pswal_top #(.FIXED(1'b1)) u_fix (
        .clk(clk), .rst_n(rst_n), .vco_tick(vco_tick), .ref_tick(ref_tick),
        .cfg_load(cfg_load), .cfg_small(cfg_small), .cfg_n(cfg_n), .cfg_a(cfg_a),
        .cfg_r(cfg_r), .div_pulse(fx_div), .ref_pulse(fx_ref), .cfg_err(fx_err)
    );

    typedef struct {
        int    len;
        string tag;
    } item_t;

    item_t q_v[$];
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int cnt_dv = 0, cnt_dr = 0, cnt_fv = 0, cnt_fr = 0;
    int cur_v    = 768 + 3;
    int r_mirror = 7;
    int r_exp    = 7;
    int fx_seen  = 0;
    bit prev_div = 1'b0;
    bit done     = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // stimulus tick patterns
    always @(negedge clk) begin
        cyc++;
        vco_tick <= (cyc % 5) != 3;
        ref_raw  <= (cyc % 3) == 0;
    end

    // edge counting
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_dv = 0; cnt_dr = 0; cnt_fv = 0; cnt_fr = 0;
        end else begin
            if (vco_tick) begin cnt_dv++; cnt_fv++; end
            if (ref_tick) begin cnt_dr++; cnt_fr++; end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (div_pulse) begin
                check("R9 pulse width", int'(prev_div), 0);
                if (q_v.size() == 0) begin
                    check("R1 unexpected pulse", 1, 0);
                end else begin
                    item_t it;
                    it = q_v.pop_front();
                    check(it.tag, cnt_dv, it.len);
                end
                cnt_dv = 0;
            end
            prev_div = div_pulse;
            if (ref_pulse) begin
                check("R4 ref period", cnt_dr, r_exp);
                r_exp  = r_mirror;
                cnt_dr = 0;
            end
            if (fx_div) begin
                check("R8 fixed vco period", cnt_fv, 16 * 291 + 7);
                cnt_fv = 0;
                fx_seen++;
            end
            if (fx_ref) begin
                check("R8 fixed ref period", cnt_fr, 384);
                cnt_fr = 0;
            end
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    task automatic step(input bit sm, input int n, input int a, input int r, input string tag);
        bit ok;
        item_t it;
        wait_pulse();
        ok = (n >= 5) && (r >= 5) && (a < n) && (!sm || a < 64);
        cfg_small = sm;
        cfg_n     = 11'(n);
        cfg_a     = 7'(a);
        cfg_r     = 14'(r);
        cfg_load  = 1'b1;
        if (ok) cur_v = (sm ? 64 : 128) * n + a;
        it.len = cur_v;
        it.tag = tag;
        q_v.push_back(it);
        @(negedge clk);
        cfg_load = 1'b0;
        check("R6 error flag", int'(cfg_err), int'(!ok));
        check("R8 fixed error flag", int'(fx_err), 0);
        if (ok) r_mirror = r;
    endtask

    initial begin
        item_t it;
        repeat (3) @(negedge clk);
        check("R7 reset div_pulse", int'(div_pulse), 0);
        check("R7 reset ref_pulse", int'(ref_pulse), 0);
        check("R7 reset cfg_err", int'(cfg_err), 0);
        check("R7 reset fixed outputs", int'(fx_div | fx_ref | fx_err), 0);
        it.len = cur_v; it.tag = "R7 R1 default period";
        q_v.push_back(it);
        q_v.push_back(it);
        rst_n = 1'b1;
        step(1'b0, 5, 0, 5,   "R3 R5 A=0");
        step(1'b1, 8, 7, 11,  "R2 R3 R5 A=N-1");
        step(1'b1, 4, 0, 9,   "R6 N<5 kept");
        step(1'b1, 9, 9, 9,   "R6 A=N kept");
        step(1'b1, 70, 64, 9, "R6 A>63 small kept");
        step(1'b1, 9, 2, 4,   "R6 R<5 kept");
        step(1'b0, 20, 19, 300, "R1 R5 large");
        step(1'b0, 20, 19, 300, "R1 reload same");
        step(1'b0, 20, 19, 300, "R1 hold");
        step(1'b0, 20, 19, 300, "R1 hold 2");
        wait_pulse();
        wait_pulse();
        check("R8 fixed pulses seen", int'(fx_seen >= 2), 1);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule